// File: doc/BRIEF.md
# Background Layer Pixel Fetch Pipeline

This block turns one screen coordinate into the color of the background pixel shown there. Each request carries an x and y position and the scroll offsets in force. The block scrolls and wraps the position over the tile grid, then reads the attribute word of the tile under it. It applies that tile's mirror flags to find the pixel inside the tile, and reads the packed 3-bit pixel code from tile storage. Finally it looks the code up in the tile's palette and returns the stored color.

The three memories are external. Each is read through a port with a fixed read latency of `RD_LAT` cycles. The pipeline never stalls and accepts one request per cycle, and results come back in request order after a constant delay. A pixel code can straddle two 16-bit tile words. The tile store therefore has two read ports, and the second one is enabled only when the straddle happens.

Top module: `bgf_pixel_pipe`

## Requirements
- R1: The scrolled position is px = (req_x + scroll_x) mod 640 and py = (req_y + scroll_y) mod 480, for req_x < 640 and req_y < 480. The scroll values are taken in the same cycle as the request.
- R2: One cycle after an accepted request, attr_rd_en is high and attr_rd_addr = 0xC000 + px/16 + (py/16)*40.
- R3: In the attribute word, bit 15 mirrors the in-tile column (15 - col) and bit 14 mirrors the in-tile row (15 - row). Bits 12..10 select the palette and bits 9..0 select the tile. Bit 13 has no effect on any output.
- R4: The pixel bit offset is off = (row*16 + col)*3 after mirroring. tile_rd_addr_a = tile*48 + off/16, and the pixel code starts at bit off mod 16 of that word, counting up from bit 0.
- R5: When off mod 16 is greater than 13, tile_rd_en_b is high, tile_rd_addr_b = tile_rd_addr_a + 1, and the high code bits come from the low bits of that second word. Otherwise tile_rd_en_b stays low.
- R6: pal_rd_addr = palette*8 + pixel code.
- R7: pix_color equals bits 11..0 of the palette word (red 11..8, green 7..4, blue 3..0). Bits 15..12 of that word are ignored.
- R8: Every request yields exactly one pix_valid pulse, 3*RD_LAT + 4 cycles later (7 with the default). Requests may arrive back to back, and results keep their order.
- R9: While rst_n is low, every read enable and pix_valid are low.

## Ports
| Port | Direction | Width | Description |
|-|-|-|-|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_x | input | 10 | Screen column |
| req_y | input | 9 | Screen row |
| scroll_x | input | 9 | Horizontal scroll offset |
| scroll_y | input | 8 | Vertical scroll offset |
| attr_rd_en | output | 1 | Attribute read enable |
| attr_rd_addr | output | 16 | Attribute word address |
| attr_rd_data | input | 16 | Attribute word, RD_LAT cycles after its address |
| tile_rd_en_a | output | 1 | First tile word read enable |
| tile_rd_addr_a | output | 16 | First tile word address |
| tile_rd_data_a | input | 16 | First tile word |
| tile_rd_en_b | output | 1 | Second tile word read enable, used for straddling codes |
| tile_rd_addr_b | output | 16 | Second tile word address |
| tile_rd_data_b | input | 16 | Second tile word |
| pal_rd_en | output | 1 | Palette read enable |
| pal_rd_addr | output | 6 | Palette entry address |
| pal_rd_data | input | 16 | Palette word |
| pix_valid | output | 1 | Result strobe |
| pix_color | output | 12 | Pixel color |

## Verification
Every internal stage leaves a visible trace, each at a fixed cycle. A wrong wrapped coordinate shows one cycle after the request as a bad attribute address. A wrong mirror or offset shows three cycles after the request as a bad tile address or a wrong second-word enable. A wrong code extraction shows five cycles after the request as a bad palette address. The bench probes these addresses on isolated requests and compares every color against its own model at the seventh cycle. Long back-to-back streams catch any slip in sideband alignment, which would show as a color from a neighbouring request.

// File: rtl/bgf_pkg.sv
`timescale 1ns/1ps
package bgf_pkg;
   localparam int ATTR_W     = 16;
   localparam int TILE_IDX_W = 10;
   localparam int PAL_IDX_W  = 3;

   // attribute word, fields from bit 15 down to bit 0
   typedef struct packed {
      logic                  hflip;
      logic                  vflip;
      logic                  spare;
      logic [PAL_IDX_W-1:0]  pal;
      logic [TILE_IDX_W-1:0] tile;
   } bg_attr_t;
endpackage

// File: rtl/bgf_delay.sv
`timescale 1ns/1ps
module bgf_delay #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (DEPTH == 0) begin : g_wire
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q = d;
      end else begin : g_pipe
         logic [W-1:0] stage [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
            end else begin
               stage[0] <= d;
               for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
            end
         end
         assign q = stage[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/bgf_scroll_stage.sv
`timescale 1ns/1ps
module bgf_scroll_stage #(
   parameter int          X_W       = 10,
   parameter int          Y_W       = 9,
   parameter int          SCX_W     = 9,
   parameter int          SCY_W     = 8,
   parameter int          TILES_X   = 40,
   parameter int          TILES_Y   = 30,
   parameter int          TILE_PX   = 16,
   parameter int          ADDR_W    = 16,
   parameter int unsigned ATTR_BASE = 'hC000,
   localparam int         COL_W     = $clog2(TILE_PX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [X_W-1:0]    in_x,
   input  logic [Y_W-1:0]    in_y,
   input  logic [SCX_W-1:0]  in_sx,
   input  logic [SCY_W-1:0]  in_sy,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_attr_addr,
   output logic [COL_W-1:0]  out_col,
   output logic [COL_W-1:0]  out_row
);
   localparam int BG_W  = TILES_X * TILE_PX;
   localparam int BG_H  = TILES_Y * TILE_PX;
   localparam int BGX_W = $clog2(BG_W);
   localparam int BGY_W = $clog2(BG_H);
   localparam int SX_W  = X_W + 1;
   localparam int SY_W  = Y_W + 1;
   localparam int TX_W  = BGX_W - COL_W;
   localparam int TY_W  = BGY_W - COL_W;

   logic [SX_W-1:0]   sum_x, wrap_x;
   logic [SY_W-1:0]   sum_y, wrap_y;
   logic [BGX_W-1:0]  pos_x;
   logic [BGY_W-1:0]  pos_y;
   logic [TX_W-1:0]   tile_x;
   logic [TY_W-1:0]   tile_y;
   logic [ADDR_W-1:0] attr_addr;

   // one conditional subtraction is enough: both terms are below the span
   always_comb begin
      sum_x  = SX_W'(in_x) + SX_W'(in_sx);
      sum_y  = SY_W'(in_y) + SY_W'(in_sy);
      wrap_x = (sum_x >= SX_W'(BG_W)) ? sum_x - SX_W'(BG_W) : sum_x;
      wrap_y = (sum_y >= SY_W'(BG_H)) ? sum_y - SY_W'(BG_H) : sum_y;
      pos_x  = BGX_W'(wrap_x);
      pos_y  = BGY_W'(wrap_y);
      tile_x = pos_x[BGX_W-1:COL_W];
      tile_y = pos_y[BGY_W-1:COL_W];
      attr_addr = ADDR_W'(ATTR_BASE) + ADDR_W'(tile_x)
                + ADDR_W'(tile_y) * ADDR_W'(TILES_X);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_attr_addr <= '0;
         out_col       <= '0;
         out_row       <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_attr_addr <= attr_addr;
            out_col       <= pos_x[COL_W-1:0];
            out_row       <= pos_y[COL_W-1:0];
         end
      end
   end
endmodule

// File: rtl/bgf_locate_stage.sv
`timescale 1ns/1ps
module bgf_locate_stage
   import bgf_pkg::*;
#(
   parameter int          TILE_PX   = 16,
   parameter int          BPP       = 3,
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 16,
   parameter int unsigned TILE_BASE = 0,
   localparam int         COL_W     = $clog2(TILE_PX),
   localparam int         BIT_W     = $clog2(DATA_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [COL_W-1:0]     in_col,
   input  logic [COL_W-1:0]     in_row,
   input  logic [DATA_W-1:0]    in_attr,
   output logic                 out_valid,
   output logic [ADDR_W-1:0]    out_word,
   output logic [BIT_W-1:0]     out_bit,
   output logic                 out_two,
   output logic [PAL_IDX_W-1:0] out_pal
);
   localparam int TILE_BITS  = TILE_PX * TILE_PX * BPP;
   localparam int WORDS_TILE = TILE_BITS / DATA_W;
   localparam int OFF_W      = $clog2(TILE_BITS);

   bg_attr_t           attr;
   logic [COL_W-1:0]   col_m, row_m;
   logic [2*COL_W-1:0] pix_idx;
   logic [OFF_W-1:0]   off;
   logic [ADDR_W-1:0]  word;
   logic [BIT_W-1:0]   bitpos;
   logic               unused_spare;

   assign attr         = bg_attr_t'(in_attr);
   assign unused_spare = attr.spare;

   // mirroring a power-of-two index is a bitwise inversion
   always_comb begin
      col_m   = attr.hflip ? ~in_col : in_col;
      row_m   = attr.vflip ? ~in_row : in_row;
      pix_idx = {row_m, col_m};
      off     = OFF_W'(pix_idx) * OFF_W'(BPP);
      bitpos  = off[BIT_W-1:0];
      word    = ADDR_W'(TILE_BASE) + ADDR_W'(attr.tile) * ADDR_W'(WORDS_TILE)
              + ADDR_W'(off >> BIT_W);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         out_bit   <= '0;
         out_two   <= 1'b0;
         out_pal   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word <= word;
            out_bit  <= bitpos;
            out_two  <= bitpos > BIT_W'(DATA_W - BPP);
            out_pal  <= attr.pal;
         end
      end
   end
endmodule

// File: rtl/bgf_extract_stage.sv
`timescale 1ns/1ps
module bgf_extract_stage
   import bgf_pkg::*;
#(
   parameter int  DATA_W = 16,
   parameter int  BPP    = 3,
   localparam int BIT_W  = $clog2(DATA_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [BIT_W-1:0]         in_bit,
   input  logic [PAL_IDX_W-1:0]     in_pal,
   input  logic [DATA_W-1:0]        in_lo,
   input  logic [DATA_W-1:0]        in_hi,
   output logic                     out_valid,
   output logic [PAL_IDX_W+BPP-1:0] out_pal_addr
);
   logic [2*DATA_W-1:0] pair;
   logic [BPP-1:0]      code;

   // low word first; a straddling code continues into the next word's bit 0
   assign pair = {in_hi, in_lo};
   assign code = BPP'(pair >> in_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_pal_addr <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_pal_addr <= {in_pal, code};
      end
   end
endmodule

// File: rtl/bgf_pixel_pipe.sv
`timescale 1ns/1ps
module bgf_pixel_pipe
   import bgf_pkg::*;
#(
   parameter int          X_W       = 10,
   parameter int          Y_W       = 9,
   parameter int          SCX_W     = 9,
   parameter int          SCY_W     = 8,
   parameter int          TILES_X   = 40,
   parameter int          TILES_Y   = 30,
   parameter int          TILE_PX   = 16,
   parameter int          BPP       = 3,
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 16,
   parameter int          COLOR_W   = 12,
   parameter int unsigned ATTR_BASE = 'hC000,
   parameter int unsigned TILE_BASE = 0,
   parameter int          RD_LAT    = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [X_W-1:0]           req_x,
   input  logic [Y_W-1:0]           req_y,
   input  logic [SCX_W-1:0]         scroll_x,
   input  logic [SCY_W-1:0]         scroll_y,
   output logic                     attr_rd_en,
   output logic [ADDR_W-1:0]        attr_rd_addr,
   input  logic [DATA_W-1:0]        attr_rd_data,
   output logic                     tile_rd_en_a,
   output logic [ADDR_W-1:0]        tile_rd_addr_a,
   input  logic [DATA_W-1:0]        tile_rd_data_a,
   output logic                     tile_rd_en_b,
   output logic [ADDR_W-1:0]        tile_rd_addr_b,
   input  logic [DATA_W-1:0]        tile_rd_data_b,
   output logic                     pal_rd_en,
   output logic [PAL_IDX_W+BPP-1:0] pal_rd_addr,
   input  logic [DATA_W-1:0]        pal_rd_data,
   output logic                     pix_valid,
   output logic [COLOR_W-1:0]       pix_color
);
   localparam int COL_W    = $clog2(TILE_PX);
   localparam int BIT_W    = $clog2(DATA_W);
   localparam int BG_W     = TILES_X * TILE_PX;
   localparam int BG_H     = TILES_Y * TILE_PX;
   localparam int PAL_AW   = PAL_IDX_W + BPP;
   localparam int SB1_W    = 2 * COL_W + 1;
   localparam int SB2_W    = BIT_W + PAL_IDX_W + 1;

   initial begin
      if ((1 << COL_W) != TILE_PX)            $fatal(1, "tile size must be a power of two");
      if ((1 << BIT_W) != DATA_W)             $fatal(1, "word width must be a power of two");
      if (DATA_W != ATTR_W)                   $fatal(1, "attribute word width mismatch");
      if ((TILE_PX*TILE_PX*BPP) % DATA_W != 0) $fatal(1, "tile must fill whole words");
      if (BPP > DATA_W)                       $fatal(1, "pixel code wider than a word");
      if ((1 << SCX_W) > BG_W || (1 << SCY_W) > BG_H) $fatal(1, "scroll exceeds map span");
      if ((1 << X_W) < BG_W || (1 << Y_W) < BG_H)     $fatal(1, "coordinate too narrow");
      if (COLOR_W > DATA_W)                   $fatal(1, "color wider than palette word");
      if (RD_LAT < 0)                         $fatal(1, "negative read latency");
   end

   // stage 1: scroll, wrap, attribute address
   logic              s1_valid;
   logic [ADDR_W-1:0] s1_attr_addr;
   logic [COL_W-1:0]  s1_col, s1_row;

   bgf_scroll_stage #(
      .X_W(X_W), .Y_W(Y_W), .SCX_W(SCX_W), .SCY_W(SCY_W),
      .TILES_X(TILES_X), .TILES_Y(TILES_Y), .TILE_PX(TILE_PX),
      .ADDR_W(ADDR_W), .ATTR_BASE(ATTR_BASE)
   ) u_scroll (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_x(req_x), .in_y(req_y),
      .in_sx(scroll_x), .in_sy(scroll_y),
      .out_valid(s1_valid), .out_attr_addr(s1_attr_addr),
      .out_col(s1_col), .out_row(s1_row)
   );

   assign attr_rd_en   = s1_valid;
   assign attr_rd_addr = s1_attr_addr;

   logic [SB1_W-1:0] sb1_q;
   bgf_delay #(.W(SB1_W), .DEPTH(RD_LAT)) u_dly1 (
      .clk(clk), .rst_n(rst_n), .d({s1_valid, s1_col, s1_row}), .q(sb1_q)
   );

   // stage 2: mirror and tile word address
   logic                 s2_valid, s2_two;
   logic [ADDR_W-1:0]    s2_word;
   logic [BIT_W-1:0]     s2_bit;
   logic [PAL_IDX_W-1:0] s2_pal;

   bgf_locate_stage #(
      .TILE_PX(TILE_PX), .BPP(BPP), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .TILE_BASE(TILE_BASE)
   ) u_locate (
      .clk(clk), .rst_n(rst_n),
      .in_valid(sb1_q[SB1_W-1]),
      .in_col(sb1_q[2*COL_W-1:COL_W]),
      .in_row(sb1_q[COL_W-1:0]),
      .in_attr(attr_rd_data),
      .out_valid(s2_valid), .out_word(s2_word), .out_bit(s2_bit),
      .out_two(s2_two), .out_pal(s2_pal)
   );

   assign tile_rd_en_a   = s2_valid;
   assign tile_rd_addr_a = s2_word;
   assign tile_rd_en_b   = s2_valid & s2_two;
   assign tile_rd_addr_b = s2_word + ADDR_W'(1);

   logic [SB2_W-1:0] sb2_q;
   bgf_delay #(.W(SB2_W), .DEPTH(RD_LAT)) u_dly2 (
      .clk(clk), .rst_n(rst_n), .d({s2_valid, s2_bit, s2_pal}), .q(sb2_q)
   );

   // stage 3: pixel code and palette address
   logic              s3_valid;
   logic [PAL_AW-1:0] s3_pal_addr;

   bgf_extract_stage #(.DATA_W(DATA_W), .BPP(BPP)) u_extract (
      .clk(clk), .rst_n(rst_n),
      .in_valid(sb2_q[SB2_W-1]),
      .in_bit(sb2_q[BIT_W+PAL_IDX_W-1:PAL_IDX_W]),
      .in_pal(sb2_q[PAL_IDX_W-1:0]),
      .in_lo(tile_rd_data_a), .in_hi(tile_rd_data_b),
      .out_valid(s3_valid), .out_pal_addr(s3_pal_addr)
   );

   assign pal_rd_en   = s3_valid;
   assign pal_rd_addr = s3_pal_addr;

   logic d3_valid;
   bgf_delay #(.W(1), .DEPTH(RD_LAT)) u_dly3 (
      .clk(clk), .rst_n(rst_n), .d(s3_valid), .q(d3_valid)
   );

   // stage 4: color register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_valid <= 1'b0;
         pix_color <= '0;
      end else begin
         pix_valid <= d3_valid;
         if (d3_valid) pix_color <= COLOR_W'(pal_rd_data);
      end
   end
endmodule

// File: rtl/bgf_pixel_pipe_chk.sv
`timescale 1ns/1ps
module bgf_pixel_pipe_chk #(
   parameter int          ADDR_W    = 16,
   parameter int          TILES_X   = 40,
   parameter int          TILES_Y   = 30,
   parameter int          TILE_PX   = 16,
   parameter int          BPP       = 3,
   parameter int          DATA_W    = 16,
   parameter int unsigned ATTR_BASE = 'hC000,
   parameter int unsigned TILE_BASE = 0,
   parameter int          RD_LAT    = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              attr_rd_en,
   input logic [ADDR_W-1:0] attr_rd_addr,
   input logic              tile_rd_en_a,
   input logic [ADDR_W-1:0] tile_rd_addr_a,
   input logic              tile_rd_en_b,
   input logic              pix_valid
);
   localparam int          PIPE_LAT  = 3 * RD_LAT + 4;
   localparam int unsigned ATTR_END  = ATTR_BASE + TILES_X * TILES_Y;
   localparam int unsigned TILE_END  = TILE_BASE
                                     + (1 << bgf_pkg::TILE_IDX_W) * (TILE_PX*TILE_PX*BPP/DATA_W);

   int inflight;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= 0;
      else        inflight <= inflight + (req_valid ? 1 : 0) - (pix_valid ? 1 : 0);
   end

   p_attr_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> attr_rd_en);

   p_attr_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
      attr_rd_en |-> (32'(attr_rd_addr) >= ATTR_BASE && 32'(attr_rd_addr) < ATTR_END));

   p_tile_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tile_rd_en_a |-> 32'(tile_rd_addr_a) < TILE_END);

   p_second_with_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tile_rd_en_b |-> tile_rd_en_a);

   p_no_orphan_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> inflight > 0);

   p_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= PIPE_LAT);
endmodule

bind bgf_pixel_pipe bgf_pixel_pipe_chk #(
   .ADDR_W(ADDR_W), .TILES_X(TILES_X), .TILES_Y(TILES_Y), .TILE_PX(TILE_PX),
   .BPP(BPP), .DATA_W(DATA_W), .ATTR_BASE(ATTR_BASE), .TILE_BASE(TILE_BASE),
   .RD_LAT(RD_LAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
   .attr_rd_en(attr_rd_en), .attr_rd_addr(attr_rd_addr),
   .tile_rd_en_a(tile_rd_en_a), .tile_rd_addr_a(tile_rd_addr_a),
   .tile_rd_en_b(tile_rd_en_b), .pix_valid(pix_valid)
);

// File: tb/sim_bgf_pixel_pipe.sv
`timescale 1ns/1ps
module sim_bgf_pixel_pipe;
   localparam int LAT = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid;
   logic [9:0]  req_x;
   logic [8:0]  req_y;
   logic [8:0]  scroll_x;
   logic [7:0]  scroll_y;
   logic        attr_rd_en, tile_rd_en_a, tile_rd_en_b, pal_rd_en, pix_valid;
   logic [15:0] attr_rd_addr, tile_rd_addr_a, tile_rd_addr_b;
   logic [15:0] attr_q, ta_q, tb_q, pal_q;
   logic [5:0]  pal_rd_addr;
   logic [11:0] pix_color;

   int errors = 0, checks = 0, cyc = 0;
   bit flip13 = 1'b0, done = 1'b0;
   int exp_q[$];
   int due_q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   bgf_pixel_pipe u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_x(req_x), .req_y(req_y),
      .scroll_x(scroll_x), .scroll_y(scroll_y),
      .attr_rd_en(attr_rd_en), .attr_rd_addr(attr_rd_addr), .attr_rd_data(attr_q),
      .tile_rd_en_a(tile_rd_en_a), .tile_rd_addr_a(tile_rd_addr_a), .tile_rd_data_a(ta_q),
      .tile_rd_en_b(tile_rd_en_b), .tile_rd_addr_b(tile_rd_addr_b), .tile_rd_data_b(tb_q),
      .pal_rd_en(pal_rd_en), .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_q),
      .pix_valid(pix_valid), .pix_color(pix_color)
   );

   function automatic logic [15:0] attr_fn(input logic [15:0] a);
      logic [31:0] h = {16'h0, a} * 32'h9E3779B1;
      return h[31:16];
   endfunction
   function automatic logic [15:0] tile_fn(input logic [15:0] a);
      logic [31:0] h = ({16'h0, a} * 32'h85EBCA6B) ^ 32'h0001_2345;
      return h[23:8];
   endfunction
   function automatic logic [15:0] pal_fn(input logic [15:0] a);
      logic [31:0] h = ({16'h0, a} + 32'd5) * 32'hC2B2AE35;
      return h[31:16];
   endfunction

   // memories with one cycle of read latency; bit 13 of attributes may be toggled
   always @(posedge clk) begin
      attr_q <= attr_fn(attr_rd_addr) ^ (flip13 ? 16'h2000 : 16'h0000);
      ta_q   <= tile_fn(tile_rd_addr_a);
      tb_q   <= tile_fn(tile_rd_addr_b);
      pal_q  <= pal_fn({10'h0, pal_rd_addr});
   end

   function automatic void model(input int x, input int y, input int sx, input int sy,
                                 output int aaddr, output int waddr, output int paddr,
                                 output bit two, output int color);
      int bx, by, col, row, off, b, pix;
      logic [15:0] a;
      logic [31:0] pair;
      bx = (x + sx) % 640;
      by = (y + sy) % 480;
      col = bx % 16;
      row = by % 16;
      aaddr = 'hC000 + bx / 16 + (by / 16) * 40;
      a = attr_fn(16'(aaddr));
      if (a[15]) col = 15 - col;
      if (a[14]) row = 15 - row;
      off = (row * 16 + col) * 3;
      b = off % 16;
      waddr = int'(a[9:0]) * 48 + off / 16;
      two = (b > 13);
      pair = {tile_fn(16'(waddr + 1)), tile_fn(16'(waddr))};
      pix = int'((pair >> b) & 32'h7);
      paddr = int'(a[12:10]) * 8 + pix;
      color = int'(pal_fn(16'(paddr)) & 16'h0FFF);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // call at a falling edge; returns one falling edge later
   task automatic issue(input int x, input int y, input int sx, input int sy);
      int aa, wa, pa, col;
      bit two;
      model(x, y, sx, sy, aa, wa, pa, two, col);
      req_valid = 1'b1;
      req_x = 10'(x); req_y = 9'(y); scroll_x = 9'(sx); scroll_y = 8'(sy);
      exp_q.push_back(col);
      due_q.push_back(cyc + LAT);
      @(negedge clk);
   endtask

   task automatic probe(input int x, input int y, input int sx, input int sy, input string tag);
      int aa, wa, pa, col;
      bit two;
      model(x, y, sx, sy, aa, wa, pa, two, col);
      issue(x, y, sx, sy);
      req_valid = 1'b0;
      chk(attr_rd_en && attr_rd_addr == 16'(aa), {"R2 attribute address, ", tag},
          int'(attr_rd_addr), aa);
      repeat (2) @(negedge clk);
      chk(tile_rd_en_a && tile_rd_addr_a == 16'(wa), {"R4 tile word, ", tag},
          int'(tile_rd_addr_a), wa);
      chk(tile_rd_en_b == two, {"R5 second read enable, ", tag}, int'(tile_rd_en_b), int'(two));
      if (two)
         chk(tile_rd_addr_b == 16'(wa + 1), {"R5 second word, ", tag}, int'(tile_rd_addr_b), wa + 1);
      repeat (2) @(negedge clk);
      chk(pal_rd_en && pal_rd_addr == 6'(pa), {"R6 palette address, ", tag},
          int'(pal_rd_addr), pa);
      repeat (4) @(negedge clk);
   endtask

   // result scoreboard (R7, R8)
   always @(negedge clk) begin
      if (rst_n && !done && pix_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 output without request", 1, 0);
         end else begin
            int e, d;
            e = exp_q.pop_front();
            d = due_q.pop_front();
            chk(int'(pix_color) == e, "R7 color", int'(pix_color), e);
            chk(cyc == d, "R8 latency", cyc, d);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL R8 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int aa, wa, pa, col, t, fx;
      bit two;
      req_valid = 1'b0; req_x = '0; req_y = '0; scroll_x = '0; scroll_y = '0;
      void'($urandom(32'd7919));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!attr_rd_en && !tile_rd_en_a && !tile_rd_en_b && !pal_rd_en && !pix_valid,
          "R9 quiet in reset",
          int'({attr_rd_en, tile_rd_en_a, tile_rd_en_b, pal_rd_en, pix_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      probe(0, 0, 0, 0, "origin");
      probe(639, 479, 0, 0, "far corner");
      probe(639, 10, 511, 0, "R1 x wrap");
      probe(5, 479, 0, 255, "R1 y wrap");
      probe(400, 300, 300, 200, "R1 both wrap");

      // a tile with both mirror flags set
      t = 0;
      while (attr_fn(16'('hC000 + t)) [15:14] != 2'b11 && t < 1199) t++;
      probe((t % 40) * 16 + 3, (t / 40) * 16 + 5, 0, 0, "R3 mirrors");

      // a code that straddles two words, and one that does not
      fx = 0;
      for (int x = 0; x < 640; x++) begin
         model(x, 0, 0, 0, aa, wa, pa, two, col);
         if (two && fx == 0) fx = x + 1;
      end
      if (fx != 0) probe(fx - 1, 0, 0, 0, "R5 straddle");
      for (int x = 0; x < 640; x++) begin
         model(x, 16, 0, 0, aa, wa, pa, two, col);
         if (!two) begin
            probe(x, 16, 0, 0, "R5 single word");
            break;
         end
      end

      // bit 13 toggled must give the same color (R3)
      flip13 = 1'b1;
      probe(123, 77, 10, 20, "R3 spare bit set");
      flip13 = 1'b0;
      probe(123, 77, 10, 20, "R3 spare bit clear");

      // random stream, mostly back to back (R1, R7, R8)
      for (int i = 0; i < 600; i++) begin
         if ($urandom_range(0, 7) == 0) begin
            req_valid = 1'b0;
            @(negedge clk);
         end else begin
            issue($urandom_range(0, 639), $urandom_range(0, 479),
                  $urandom_range(0, 511), $urandom_range(0, 255));
         end
      end
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R8 every request answered", exp_q.size(), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule